// File: doc/BRIEF.md
# Cache-Line Wrap Burst Address Generator

This block produces the word addresses for one memory read burst, one address per beat. The burst may run in cache-line wrap mode. A line-size register, which software writes through a small configuration port, sets the wrap boundary. While that register holds a supported size, the burst address stays inside the aligned line that contains the start address. When the address passes the top of that line it returns to the bottom of the same line. When the register holds zero, wrapping is off and the address counts upward with no boundary.

The register accepts only power-of-two sizes from 16 to 128 bytes, encoded in 32-bit words. Any other value written to it clears it to zero, and zero is also its reset value. A burst starts when a request arrives while the generator is idle. The request carries a start address and a beat count. The line size is captured at that moment. Each beat address is held until the consumer accepts it. A last-beat flag marks the final beat.

The block exists because both ends of a wrapping transfer must agree on the line size. A master and a target set to different sizes walk different addresses from the same start. The bench demonstrates this with the 32-byte and 64-byte cases.

Top module: `wrap_burst_gen`

## Requirements
- R1: A configuration write of 4, 8, 16 or 32 (line size in 32-bit words, that is 16, 32, 64 or 128 bytes) is stored. The value reads back on `cfgLineWords` from the cycle after the write.
- R2: A configuration write of any other value, zero included, leaves `cfgLineWords` at 0 from the next cycle.
- R3: Every beat address is word aligned. The two low bits of the start address are cleared. Each accepted non-final beat moves the address forward by 4 bytes, subject to R4.
- R4: With a nonzero line size of L bytes, the address bits at L and above stay fixed for the whole burst. The offset below L increments modulo L. With a 32-byte line (8 words), a start at 0x118 gives 0x118, 0x11C, 0x100, 0x104.
- R5: With a 64-byte line (16 words) and the same start 0x118, the beats are 0x118, 0x11C, 0x120, 0x124. This differs from the sequence in R4.
- R6: With line size 0, addresses increment linearly and cross any line boundary.
- R7: `beatValid` rises in the cycle after an accepted start. `beatLast` is high exactly on the final beat of the requested count, and only while `beatValid` is high. `beatValid` is low in the cycle after the final beat is accepted. A start with a beat count of 0 starts nothing.
- R8: A start request that arrives while a burst is active is ignored. The active burst keeps its addresses and its beat count.
- R9: While `beatValid` is high and `beatAccept` is low, `beatAddr` and `beatValid` hold their values.
- R10: The line size is captured when a burst starts. A configuration write during a burst does not change that burst's wrap boundary.
- R11: After reset, `beatValid` and `beatLast` are 0 and `cfgLineWords` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Line-size register write strobe |
| cfgWrData | input | 8 | Line size to write, in 32-bit words |
| cfgLineWords | output | 8 | Current line-size register value |
| startReq | input | 1 | Burst start request |
| startAddr | input | 32 | Byte address of the first beat |
| startBeats | input | 8 | Number of beats in the burst |
| beatAccept | input | 1 | Consumer takes the current beat |
| beatAddr | output | 32 | Address of the current beat |
| beatValid | output | 1 | A beat address is presented |
| beatLast | output | 1 | Current beat is the final one |

## Verification
The assertions rely on the configuration port carrying only 8-bit word counts. They also rely on `beatAccept` and `startReq` being single-cycle levels sampled at the rising edge. They do not assume that start requests are withheld during a burst, so the stimulus sends one on purpose in the middle of a burst. The stimulus changes every input half a cycle away from the sampling edge. All start addresses stay far below the top of the address space, so linear bursts never overflow.

// File: rtl/wbg_pkg.sv
package wbg_pkg;
  typedef struct packed {
    logic load;  // capture start address and line mask
    logic step;  // advance to the next beat address
  } wbgStrobes_t;
endpackage

// File: rtl/wbg_datapath.sv
module wbg_datapath
  import wbg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LSZ_W     = 8,
  parameter int MIN_WORDS = 4,
  parameter int MAX_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [LSZ_W-1:0]  cfgWrData,
  input  logic [ADDR_W-1:0] startAddr,
  input  wbgStrobes_t       strobes,
  output logic [LSZ_W-1:0]  lineWords,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFF_W = $clog2(MAX_WORDS) + 2;

  logic [OFF_W-1:0]  burstMask;
  logic [OFF_W-1:0]  newMask;
  logic [LSZ_W+1:0]  lineBytesM1;
  logic [ADDR_W-1:0] fullMask;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              wrLegal;

  // legal: power of two inside the supported word range
  always_comb begin
    wrLegal = (int'(cfgWrData) >= MIN_WORDS) && (int'(cfgWrData) <= MAX_WORDS)
              && ((cfgWrData & (cfgWrData - LSZ_W'(1))) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) lineWords <= '0;
    else if (cfgWrEn) lineWords <= wrLegal ? cfgWrData : '0;
  end

  always_comb begin
    lineBytesM1 = {lineWords, 2'b00} - (LSZ_W+2)'(1);
    newMask     = (lineWords == '0) ? '0 : lineBytesM1[OFF_W-1:0];
  end

  always_comb begin
    fullMask = {{(ADDR_W-OFF_W){1'b0}}, burstMask};
    incAddr  = addr + ADDR_W'(4);
    if (burstMask == '0) nextAddr = incAddr;
    else nextAddr = (addr & ~fullMask) | (incAddr & fullMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr      <= '0;
      burstMask <= '0;
    end else if (strobes.load) begin
      addr      <= {startAddr[ADDR_W-1:2], 2'b00};
      burstMask <= newMask;
    end else if (strobes.step) begin
      addr <= nextAddr;
    end
  end
endmodule

// File: rtl/wbg_ctrl.sv
module wbg_ctrl
  import wbg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] startBeats,
  input  logic             beatAccept,
  output wbgStrobes_t      strobes,
  output logic             valid,
  output logic             last
);
  logic [CNT_W-1:0] remaining;
  logic             startOk;

  always_comb begin
    startOk      = startReq && !valid && (startBeats != '0);
    last         = valid && (remaining == CNT_W'(1));
    strobes.load = startOk;
    strobes.step = valid && beatAccept && !last;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid     <= 1'b0;
      remaining <= '0;
    end else if (startOk) begin
      valid     <= 1'b1;
      remaining <= startBeats;
    end else if (valid && beatAccept) begin
      if (last) valid <= 1'b0;
      else remaining <= remaining - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wrap_burst_gen.sv
module wrap_burst_gen
  import wbg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LSZ_W     = 8,
  parameter int CNT_W     = 8,
  parameter int MIN_WORDS = 4,
  parameter int MAX_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [LSZ_W-1:0]  cfgWrData,
  output logic [LSZ_W-1:0]  cfgLineWords,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  startBeats,
  input  logic              beatAccept,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatValid,
  output logic              beatLast
);
  wbgStrobes_t strobes;

  wbg_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startBeats(startBeats),
    .beatAccept(beatAccept), .strobes(strobes), .valid(beatValid), .last(beatLast)
  );

  wbg_datapath #(
    .ADDR_W(ADDR_W), .LSZ_W(LSZ_W), .MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS)
  ) uData (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .startAddr(startAddr), .strobes(strobes), .lineWords(cfgLineWords), .addr(beatAddr)
  );
endmodule

// File: rtl/wrap_burst_chk.sv
module wrap_burst_chk #(
  parameter int ADDR_W    = 32,
  parameter int LSZ_W     = 8,
  parameter int CNT_W     = 8,
  parameter int MIN_WORDS = 4,
  parameter int MAX_WORDS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [LSZ_W-1:0]  cfgWrData,
  input logic [LSZ_W-1:0]  cfgLineWords,
  input logic              startReq,
  input logic [CNT_W-1:0]  startBeats,
  input logic              beatAccept,
  input logic [ADDR_W-1:0] beatAddr,
  input logic              beatValid,
  input logic              beatLast
);
  logic wrOk;
  always_comb wrOk = (int'(cfgWrData) >= MIN_WORDS) && (int'(cfgWrData) <= MAX_WORDS)
                     && ($countones(cfgWrData) == 1);

  AST_GOOD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && wrOk |=> cfgLineWords == $past(cfgWrData)); // R1
  AST_BAD_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && !wrOk |=> cfgLineWords == '0); // R2
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> beatAddr[1:0] == 2'b00); // R3
  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatAccept && beatLast |=> !beatValid); // R7
  AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && startReq && !beatAccept |=> beatValid && $stable(beatAddr)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatAccept |=> beatValid && $stable(beatAddr) && $stable(beatLast)); // R9
  AST_NO_NEXT_START: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid && !startReq |=> !beatValid); // R7
endmodule

bind wrap_burst_gen wrap_burst_chk #(
  .ADDR_W(ADDR_W), .LSZ_W(LSZ_W), .CNT_W(CNT_W), .MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS)
) uChk (.*);

// File: tb/sim_wrap_burst_gen.sv
`timescale 1ns/1ps
module sim_wrap_burst_gen;
  typedef struct packed {
    logic [7:0]  lw;
    logic [31:0] a0, a1, a2, a3;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd8,  32'h118, 32'h11C, 32'h100, 32'h104},  // R4 32-byte line
    '{8'd16, 32'h118, 32'h11C, 32'h120, 32'h124},  // R5 64-byte line
    '{8'd4,  32'h10C, 32'h100, 32'h104, 32'h108},  // R4 16-byte line
    '{8'd32, 32'h1F8, 32'h1FC, 32'h180, 32'h184},  // R4 128-byte line
    '{8'd0,  32'h1F8, 32'h1FC, 32'h200, 32'h204},  // R6 linear
    '{8'd8,  32'h100, 32'h104, 32'h108, 32'h10C}   // R4 no wrap reached
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgLineWords;
  logic startReq = 1'b0;
  logic [31:0] startAddr = '0;
  logic [7:0] startBeats = '0;
  logic beatAccept = 1'b0;
  logic [31:0] beatAddr;
  logic beatValid, beatLast;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] seen [2][4];

  always #4 clk = ~clk;

  wrap_burst_gen u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] d);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic startBurst(input logic [31:0] a, input logic [7:0] n);
    startReq = 1'b1; startAddr = a; startBeats = n;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic beat(input logic [31:0] exp, input bit expLast, input string tag);
    chk(beatValid === 1'b1, {tag, " valid"}, 32'(beatValid), 32'd1);
    chk(beatAddr === exp, {tag, " addr"}, beatAddr, exp);
    chk(beatLast === expLast, {tag, " last"}, 32'(beatLast), 32'(expLast));
    beatAccept = 1'b1;
    @(negedge clk);
    beatAccept = 1'b0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(beatValid === 1'b0, "R11 valid", 32'(beatValid), 0);
    chk(beatLast === 1'b0, "R11 last", 32'(beatLast), 0);
    chk(cfgLineWords === 8'd0, "R11 line", 32'(cfgLineWords), 0);
    rstN = 1'b1;
    @(negedge clk);

    // vector table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      writeCfg(VECS[v].lw);
      chk(cfgLineWords === VECS[v].lw, "R1 readback", 32'(cfgLineWords), 32'(VECS[v].lw));
      startBurst(VECS[v].a0, 8'd4);
      for (int b = 0; b < 4; b++) begin
        logic [31:0] e;
        e = (b == 0) ? VECS[v].a0 : (b == 1) ? VECS[v].a1 : (b == 2) ? VECS[v].a2 : VECS[v].a3;
        if (v < 2) seen[v][b] = beatAddr;
        beat(e, b == 3, "R4/R5/R6 table");
      end
      chk(beatValid === 1'b0, "R7 drop after last", 32'(beatValid), 0);
    end

    // R5 mismatched line sizes give different walks from the same start
    chk(seen[0][2] !== seen[1][2], "R5 mismatch beat2", seen[0][2], 32'h100);
    chk(seen[0][3] !== seen[1][3], "R5 mismatch beat3", seen[0][3], 32'h104);

    // R2 unsupported sizes clear the register
    foreach (VECS[i]) begin end
    writeCfg(8'd16);
    writeCfg(8'd5);
    chk(cfgLineWords === 8'd0, "R2 write 5", 32'(cfgLineWords), 0);
    writeCfg(8'd8);
    writeCfg(8'd64);
    chk(cfgLineWords === 8'd0, "R2 write 64", 32'(cfgLineWords), 0);
    writeCfg(8'd8);
    writeCfg(8'd2);
    chk(cfgLineWords === 8'd0, "R2 write 2", 32'(cfgLineWords), 0);
    writeCfg(8'd32);
    writeCfg(8'd12);
    chk(cfgLineWords === 8'd0, "R2 write 12", 32'(cfgLineWords), 0);

    // R3 unaligned start is word aligned, linear with line 0
    startBurst(32'h0000_0403, 8'd2);
    beat(32'h400, 1'b0, "R3 aligned");
    beat(32'h404, 1'b1, "R3 step");

    // R7 zero-beat request starts nothing
    startBurst(32'h300, 8'd0);
    chk(beatValid === 1'b0, "R7 zero beats", 32'(beatValid), 0);

    // R9 hold without accept, R8 busy start ignored
    writeCfg(8'd16);
    startBurst(32'h200, 8'd3);
    repeat (3) @(negedge clk);
    chk(beatAddr === 32'h200, "R9 hold addr", beatAddr, 32'h200);
    chk(beatValid === 1'b1, "R9 hold valid", 32'(beatValid), 1);
    startBurst(32'h40, 8'd5);
    chk(beatAddr === 32'h200, "R8 busy start addr", beatAddr, 32'h200);
    beat(32'h200, 1'b0, "R8 beat0");
    beat(32'h204, 1'b0, "R8 beat1");
    beat(32'h208, 1'b1, "R8 beat2 last");
    chk(beatValid === 1'b0, "R8 count kept", 32'(beatValid), 0);

    // R10 config write mid-burst does not move the boundary
    writeCfg(8'd8);
    startBurst(32'h118, 8'd4);
    beat(32'h118, 1'b0, "R10 beat0");
    writeCfg(8'd16);
    chk(cfgLineWords === 8'd16, "R10 reg updated", 32'(cfgLineWords), 16);
    beat(32'h11C, 1'b0, "R10 beat1");
    beat(32'h100, 1'b0, "R10 beat2 wraps on old size");
    beat(32'h104, 1'b1, "R10 beat3");
    chk(beatValid === 1'b0, "R10 end", 32'(beatValid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule